// File: doc/BRIEF.md
# Processor Register Set with Context Stacking

This block holds the architectural state of a small 8-bit processor core: an accumulator, two byte-wide index registers, a 16-bit program counter, a stack pointer confined to one page and a condition code byte. The instruction decoder writes these registers through individual enables. It reads them back on dedicated outputs. One of those outputs, the "current index" output, follows a prefix flag. When the flag is set, index reads and writes go to the second index register (Y) instead of the first (X).

A small sequencer shares a synchronous byte-wide memory port. It uses the port for three jobs. After reset it fetches the start address from the two-byte vector at FFFEh/FFFFh. On an interrupt request it saves the context onto the stack. On a return strobe it restores that context. The context is the program counter, X, the accumulator and the condition codes. Y is deliberately left out of the context, so software must save and restore Y itself. While the sequencer is busy, `ready` is low, and decoder writes and new requests are dropped.

Top module: `core_regset`

## Requirements
- R1: After reset is released, the block reads FFFEh in the first cycle and FFFFh in the second. The byte returned for FFFEh becomes PC[15:8] and the byte for FFFFh becomes PC[7:0]. `ready` stays low for three cycles and is high in the fourth.
- R2: Reset sets the stack pointer to 017Fh and the condition code byte to E8h. The condition code layout is bit 4 H, bit 3 I, bit 2 N, bit 1 Z, bit 0 C.
- R3: The upper byte of the stack pointer always reads 01h. A decoder write to the stack pointer replaces only its low byte. That low byte wraps between 00h and FFh inside page 01h.
- R4: Bits 7 to 5 of the condition code byte always read 1, whatever value is written or popped.
- R5: An interrupt request accepted while `ready` is high starts five write cycles on the next cycle. The bytes are written in this order: PC low, PC high, X, accumulator, condition codes. Each byte goes to 01h:SP, and SP then decrements. `ready` is low for exactly those five cycles, and Y is never written.
- R6: After the context has been saved, the I bit (bit 3) is 1 and the other condition code bits are unchanged.
- R7: A return strobe accepted while `ready` is high restores the context in reverse order: condition codes, accumulator, X, PC high, PC low. For each byte, SP is incremented first and the byte is then read from 01h:SP. `ready` is low for six cycles, Y is unchanged, and the saved I value comes back with the condition codes.
- R8: After `prefix_seen`, the index write enable and `idx_out` refer to Y. An `insn_done` without `prefix_seen` in the same cycle returns them to X.
- R9: While `ready` is low, register write enables, `pc_load`, `irq_req` and `rti_req` have no effect.
- R10: A decoder write made while `ready` is high is visible on the outputs in the next cycle.
- R11: If `irq_req` and `rti_req` arrive in the same cycle, the interrupt save is performed and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Start context save |
| rti_req | input | 1 | Start context restore |
| wr_a | input | 1 | Write accumulator from wr_data |
| wr_idx | input | 1 | Write current index register from wr_data |
| wr_sp | input | 1 | Write stack pointer low byte from wr_data |
| wr_cc | input | 1 | Write condition codes from wr_data |
| wr_data | input | 8 | Decoder write data |
| pc_load | input | 1 | Load program counter from pc_data |
| pc_data | input | 16 | Program counter load value |
| prefix_seen | input | 1 | Prefix byte decoded; redirect index to Y |
| insn_done | input | 1 | Instruction completed |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| ready | output | 1 | Sequencer idle; requests and writes accepted |
| acc_out | output | 8 | Accumulator |
| x_out | output | 8 | X index register |
| y_out | output | 8 | Y index register |
| idx_out | output | 8 | Index register currently selected by the prefix flag |
| pc_out | output | 16 | Program counter |
| sp_out | output | 16 | Stack pointer |
| cc_out | output | 8 | Condition code byte |

## Verification
Decoder writes show up at the first falling edge after the rising edge that takes them. The bench therefore samples every register one cycle after each write. The save sequence places a write on the port at each of the five falling edges after the request. The restore takes six cycles: the read data arrives one cycle after each address, so the last byte is captured one cycle after the last address. The bench counts the falling edges with `ready` low after each strobe and compares that count with five or six. The reset vector is checked on the address bus at the release edge and at the edge after it, and the program counter is checked when `ready` rises. A scoreboard queue holds the expected stack writes, and a monitor matches them one by one against the write strobes at the falling edge.

// File: rtl/core_regset_pkg.sv
package core_regset_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 16;
    localparam int CTX_BYTES = 5;
    localparam int CNT_W     = $clog2(CTX_BYTES);

    localparam logic [ADDR_W-1:0] VEC_HI_ADDR = 16'hFFFE;
    localparam logic [ADDR_W-1:0] VEC_LO_ADDR = 16'hFFFF;
    localparam logic [BYTE_W-1:0] STACK_PAGE  = 8'h01;
    localparam logic [BYTE_W-1:0] CC_FORCED   = 8'hE0;
    localparam logic [BYTE_W-1:0] CC_RESET    = 8'hE8;
    localparam int                CC_I        = 3;

    // Context bytes; slot number is the push order
    typedef enum logic [2:0] {
        ITM_PCL, ITM_PCH, ITM_X, ITM_A, ITM_CC
    } ctx_item_e;

    typedef enum logic [2:0] {
        SQ_VHI, SQ_VLO, SQ_VFIN, SQ_IDLE, SQ_PUSH, SQ_POP, SQ_POPFIN
    } seq_state_e;

    typedef struct packed {
        logic      push;
        logic      pop_step;
        logic      cap_en;
        ctx_item_e push_item;
        ctx_item_e cap_item;
        logic      set_i;
    } seq_ctl_t;

    function automatic ctx_item_e item_at(input logic [CNT_W-1:0] slot);
        case (slot)
            3'd0:    return ITM_PCL;
            3'd1:    return ITM_PCH;
            3'd2:    return ITM_X;
            3'd3:    return ITM_A;
            default: return ITM_CC;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] cc_fix(input logic [BYTE_W-1:0] v);
        return v | CC_FORCED;
    endfunction

endpackage

// File: rtl/core_regset_seq.sv
module core_regset_seq
    import core_regset_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req,
    input  logic              rti_req,
    input  logic [BYTE_W-1:0] sp_lo,
    output seq_ctl_t          ctl,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              ready
);

    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(CTX_BYTES - 1);
    localparam logic [CNT_W-1:0] SLOT_SPAN = CNT_W'(CTX_BYTES);

    seq_state_e       state;
    logic [CNT_W-1:0] slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_VHI;
            slot  <= '0;
        end else begin
            case (state)
                SQ_VHI:  state <= SQ_VLO;
                SQ_VLO:  state <= SQ_VFIN;
                SQ_VFIN: state <= SQ_IDLE;
                SQ_IDLE: begin
                    slot <= '0;
                    if (irq_req)      state <= SQ_PUSH;
                    else if (rti_req) state <= SQ_POP;
                end
                SQ_PUSH: begin
                    if (slot == LAST_SLOT) state <= SQ_IDLE;
                    else                   slot  <= slot + 1'b1;
                end
                SQ_POP: begin
                    if (slot == LAST_SLOT) state <= SQ_POPFIN;
                    else                   slot  <= slot + 1'b1;
                end
                SQ_POPFIN: state <= SQ_IDLE;
                default:   state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl           = '0;
        ctl.push_item = ITM_PCL;
        ctl.cap_item  = ITM_PCL;
        mem_addr      = '0;
        mem_we        = 1'b0;
        case (state)
            SQ_VHI: mem_addr = VEC_HI_ADDR;
            SQ_VLO: begin
                mem_addr     = VEC_LO_ADDR;
                ctl.cap_en   = 1'b1;
                ctl.cap_item = ITM_PCH;
            end
            SQ_VFIN: begin
                ctl.cap_en   = 1'b1;
                ctl.cap_item = ITM_PCL;
            end
            SQ_PUSH: begin
                mem_we        = 1'b1;
                mem_addr      = {STACK_PAGE, sp_lo};
                ctl.push      = 1'b1;
                ctl.push_item = item_at(slot);
                ctl.set_i     = (slot == LAST_SLOT);
            end
            SQ_POP: begin
                mem_addr     = {STACK_PAGE, sp_lo + 8'd1};
                ctl.pop_step = 1'b1;
                ctl.cap_en   = (slot != '0);
                ctl.cap_item = item_at(SLOT_SPAN - slot);
            end
            SQ_POPFIN: begin
                ctl.cap_en   = 1'b1;
                ctl.cap_item = item_at('0);
            end
            default: ;
        endcase
    end

    assign ready = (state == SQ_IDLE);

    // R1: low vector byte is always addressed right after the high one
    p_vec_order_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_addr == VEC_LO_ADDR) |-> ($past(mem_addr) == VEC_HI_ADDR))
        else $error("p_vec_order_r1");

    // R5: stack writes stay inside the stack page
    p_stack_page_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[ADDR_W-1:BYTE_W] == STACK_PAGE))
        else $error("p_stack_page_r5");

    // R5: a save burst only begins after an interrupt request
    p_push_start_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> $past(irq_req))
        else $error("p_push_start_r5");

endmodule

// File: rtl/core_regset_file.sv
module core_regset_file
    import core_regset_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SP_RESET_LO = 8'h7F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ready,
    input  seq_ctl_t          ctl,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              wr_a,
    input  logic              wr_idx,
    input  logic              wr_sp,
    input  logic              wr_cc,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              pc_load,
    input  logic [ADDR_W-1:0] pc_data,
    input  logic              prefix_seen,
    input  logic              insn_done,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [BYTE_W-1:0] acc_out,
    output logic [BYTE_W-1:0] x_out,
    output logic [BYTE_W-1:0] y_out,
    output logic [BYTE_W-1:0] idx_out,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic [BYTE_W-1:0] cc_out,
    output logic [BYTE_W-1:0] sp_lo
);

    logic [BYTE_W-1:0] acc_r, x_r, y_r, cc_r, sp_lo_r;
    logic [ADDR_W-1:0] pc_r;
    logic              pre_r;

    // Data registers: contents undefined until written
    always_ff @(posedge clk) begin
        if (ctl.cap_en) begin
            case (ctl.cap_item)
                ITM_A:   acc_r <= mem_rdata;
                ITM_X:   x_r   <= mem_rdata;
                ITM_PCH: pc_r[ADDR_W-1:BYTE_W] <= mem_rdata;
                ITM_PCL: pc_r[BYTE_W-1:0]      <= mem_rdata;
                default: ;
            endcase
        end else if (ready) begin
            if (wr_a) acc_r <= wr_data;
            if (wr_idx) begin
                if (pre_r) y_r <= wr_data;
                else       x_r <= wr_data;
            end
            if (pc_load) pc_r <= pc_data;
        end
    end

    // Control registers with a defined reset value
    always_ff @(posedge clk) begin
        if (rst) begin
            sp_lo_r <= SP_RESET_LO;
            cc_r    <= CC_RESET;
            pre_r   <= 1'b0;
        end else begin
            if (ctl.push)                sp_lo_r <= sp_lo_r - 8'd1;
            else if (ctl.pop_step)       sp_lo_r <= sp_lo_r + 8'd1;
            else if (ready && wr_sp)     sp_lo_r <= wr_data;

            if (ctl.cap_en && ctl.cap_item == ITM_CC) cc_r <= cc_fix(mem_rdata);
            else if (ctl.set_i)                       cc_r[CC_I] <= 1'b1;
            else if (ready && wr_cc)                  cc_r <= cc_fix(wr_data);

            if (ready) begin
                if (prefix_seen)    pre_r <= 1'b1;
                else if (insn_done) pre_r <= 1'b0;
            end
        end
    end

    always_comb begin
        case (ctl.push_item)
            ITM_PCL: mem_wdata = pc_r[BYTE_W-1:0];
            ITM_PCH: mem_wdata = pc_r[ADDR_W-1:BYTE_W];
            ITM_X:   mem_wdata = x_r;
            ITM_A:   mem_wdata = acc_r;
            default: mem_wdata = cc_r;
        endcase
    end

    assign acc_out = acc_r;
    assign x_out   = x_r;
    assign y_out   = y_r;
    assign idx_out = pre_r ? y_r : x_r;
    assign pc_out  = pc_r;
    assign sp_out  = {STACK_PAGE, sp_lo_r};
    assign cc_out  = cc_r;
    assign sp_lo   = sp_lo_r;

    // R4: top three condition bits never drop
    p_cc_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        cc_r[BYTE_W-1:5] == 3'b111)
        else $error("p_cc_fixed_r4");

    // R5: each saved byte moves the stack pointer down by one
    p_sp_push_r5: assert property (@(posedge clk) disable iff (rst)
        ctl.push |=> (sp_lo_r == $past(sp_lo_r) - 8'd1))
        else $error("p_sp_push_r5");

    // R6: interrupt mask is set once the condition codes are saved
    p_i_set_r6: assert property (@(posedge clk) disable iff (rst)
        ctl.set_i |=> cc_r[CC_I])
        else $error("p_i_set_r6");

    // R9: while busy, only the sequencer moves the stack pointer
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ready && !ctl.push && !ctl.pop_step) |=> $stable(sp_lo_r))
        else $error("p_busy_hold_r9");

    // R8: instruction completion without a new prefix clears the redirect
    p_prefix_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (ready && insn_done && !prefix_seen) |=> !pre_r)
        else $error("p_prefix_clear_r8");

endmodule

// File: rtl/core_regset.sv
module core_regset
    import core_regset_pkg::*;
#(
    parameter logic [7:0] SP_RESET_LO = 8'h7F
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq_req,
    input  logic        rti_req,
    input  logic        wr_a,
    input  logic        wr_idx,
    input  logic        wr_sp,
    input  logic        wr_cc,
    input  logic [7:0]  wr_data,
    input  logic        pc_load,
    input  logic [15:0] pc_data,
    input  logic        prefix_seen,
    input  logic        insn_done,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic [7:0]  mem_wdata,
    output logic        ready,
    output logic [7:0]  acc_out,
    output logic [7:0]  x_out,
    output logic [7:0]  y_out,
    output logic [7:0]  idx_out,
    output logic [15:0] pc_out,
    output logic [15:0] sp_out,
    output logic [7:0]  cc_out
);

    seq_ctl_t          ctl;
    logic [BYTE_W-1:0] sp_lo;

    core_regset_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .irq_req  (irq_req),
        .rti_req  (rti_req),
        .sp_lo    (sp_lo),
        .ctl      (ctl),
        .mem_addr (mem_addr),
        .mem_we   (mem_we),
        .ready    (ready)
    );

    core_regset_file #(
        .SP_RESET_LO (SP_RESET_LO)
    ) u_file (
        .clk         (clk),
        .rst         (rst),
        .ready       (ready),
        .ctl         (ctl),
        .mem_rdata   (mem_rdata),
        .wr_a        (wr_a),
        .wr_idx      (wr_idx),
        .wr_sp       (wr_sp),
        .wr_cc       (wr_cc),
        .wr_data     (wr_data),
        .pc_load     (pc_load),
        .pc_data     (pc_data),
        .prefix_seen (prefix_seen),
        .insn_done   (insn_done),
        .mem_wdata   (mem_wdata),
        .acc_out     (acc_out),
        .x_out       (x_out),
        .y_out       (y_out),
        .idx_out     (idx_out),
        .pc_out      (pc_out),
        .sp_out      (sp_out),
        .cc_out      (cc_out),
        .sp_lo       (sp_lo)
    );

endmodule

// File: tb/core_regset_bench.sv
module core_regset_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] VEC_H = 8'hC3;
    localparam logic [7:0] VEC_L = 8'h5A;

    logic        clk = 1'b0, rst = 1'b1;
    logic        irq_req = 0, rti_req = 0, wr_a = 0, wr_idx = 0, wr_sp = 0, wr_cc = 0;
    logic [7:0]  wr_data = '0;
    logic        pc_load = 0, prefix_seen = 0, insn_done = 0;
    logic [15:0] pc_data = '0;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic        mem_we, ready;
    logic [7:0]  mem_wdata, acc_out, x_out, y_out, idx_out, cc_out;

    core_regset u_core_regset (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: vector bytes plus stack page, one-cycle read latency
    logic [7:0] stk [0:255];
    always_ff @(posedge clk) begin
        if (mem_we) stk[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= (mem_addr == 16'hFFFE) ? VEC_H :
                     (mem_addr == 16'hFFFF) ? VEC_L : stk[mem_addr[7:0]];
    end

    int n_checks = 0, n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard of expected stack writes
    typedef struct { logic [15:0] a; logic [7:0] d; } wr_item_t;
    wr_item_t exp_q[$];

    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (exp_q.size() == 0) begin
                chk("R5 unexpected write addr", {16'h0, mem_addr}, 32'hFFFF_FFFF);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                chk("R5 write addr", mem_addr, e.a);
                chk("R5 write data", mem_wdata, e.d);
            end
        end
    end

    // Reference model
    logic [7:0]  m_a, m_x, m_y, m_cc, m_sp;
    logic [15:0] m_pc;
    logic        m_pre;
    logic [7:0]  mstk [0:255];

    task automatic tick; @(negedge clk); endtask

    task automatic chk_regs(input string req);
        chk({req, " acc"}, acc_out, m_a);
        chk({req, " x"},   x_out,   m_x);
        chk({req, " y"},   y_out,   m_y);
        chk({req, " idx"}, idx_out, m_pre ? m_y : m_x);
        chk({req, " pc"},  pc_out,  m_pc);
        chk({req, " sp"},  sp_out,  {8'h01, m_sp});
        chk({req, " cc"},  cc_out,  m_cc);
    endtask

    // kind: 0 acc, 1 index, 2 sp, 3 cc
    task automatic dec_wr(input int kind, input logic [7:0] d);
        wr_data = d;
        case (kind)
            0: begin wr_a = 1; m_a = d; end
            1: begin wr_idx = 1; if (m_pre) m_y = d; else m_x = d; end
            2: begin wr_sp = 1; m_sp = d; end
            default: begin wr_cc = 1; m_cc = d | 8'hE0; end
        endcase
        tick;
        wr_a = 0; wr_idx = 0; wr_sp = 0; wr_cc = 0;
    endtask

    task automatic load_pc(input logic [15:0] v);
        pc_data = v; pc_load = 1; m_pc = v;
        tick;
        pc_load = 0;
    endtask

    task automatic do_irq(input logic also_rti, input logic poke);
        logic [7:0] b [5];
        int n;
        b = '{m_pc[7:0], m_pc[15:8], m_x, m_a, m_cc};
        for (int i = 0; i < 5; i++) begin
            exp_q.push_back('{a: {8'h01, m_sp}, d: b[i]});
            mstk[m_sp] = b[i];
            m_sp = m_sp - 8'd1;
        end
        m_cc = m_cc | 8'h08;
        irq_req = 1; rti_req = also_rti;
        tick;
        irq_req = 0; rti_req = 0;
        n = 0;
        while (!ready && n < 20) begin
            if (poke && n == 0) begin
                wr_a = 1; wr_data = 8'h99; pc_load = 1; pc_data = 16'hDEAD; rti_req = 1;
            end
            n++;
            tick;
            wr_a = 0; pc_load = 0; rti_req = 0;
        end
        chk("R5 save busy cycles", n, 5);
        chk("R5 all expected writes seen", exp_q.size(), 0);
    endtask

    task automatic do_rti;
        int n;
        m_sp = m_sp + 8'd1; m_cc = mstk[m_sp] | 8'hE0;
        m_sp = m_sp + 8'd1; m_a = mstk[m_sp];
        m_sp = m_sp + 8'd1; m_x = mstk[m_sp];
        m_sp = m_sp + 8'd1; m_pc[15:8] = mstk[m_sp];
        m_sp = m_sp + 8'd1; m_pc[7:0] = mstk[m_sp];
        rti_req = 1;
        tick;
        rti_req = 0;
        n = 0;
        while (!ready && n < 20) begin n++; tick; end
        chk("R7 restore busy cycles", n, 6);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        m_pre = 0; m_a = 0; m_x = 0; m_y = 0;
        repeat (3) tick;
        rst = 0;
        // R1: vector fetch order and ready timing
        chk("R1 first read addr", mem_addr, 16'hFFFE);
        chk("R1 ready low c0", ready, 0);
        tick;
        chk("R1 second read addr", mem_addr, 16'hFFFF);
        chk("R1 ready low c1", ready, 0);
        tick;
        chk("R1 ready low c2", ready, 0);
        tick;
        chk("R1 ready high c3", ready, 1);
        chk("R1 pc from vector", pc_out, {VEC_H, VEC_L});
        // R2: reset values
        chk("R2 sp reset", sp_out, 16'h017F);
        chk("R2 cc reset", cc_out, 8'hE8);
        m_pc = {VEC_H, VEC_L}; m_sp = 8'h7F; m_cc = 8'hE8;

        // R10: writes visible next cycle
        dec_wr(0, 8'h11);
        chk("R10 acc next cycle", acc_out, 8'h11);
        dec_wr(1, 8'h22);
        chk("R10 x next cycle", x_out, 8'h22);

        // R8: prefix redirects index to Y
        prefix_seen = 1; tick; prefix_seen = 0; m_pre = 1;
        dec_wr(1, 8'h33);
        chk("R8 y written under prefix", y_out, 8'h33);
        chk("R8 x untouched under prefix", x_out, 8'h22);
        chk("R8 idx shows y", idx_out, 8'h33);
        insn_done = 1; tick; insn_done = 0; m_pre = 0;
        chk("R8 idx back to x", idx_out, 8'h22);

        // R4: forced condition bits
        dec_wr(3, 8'h05);
        chk("R4 cc top bits forced", cc_out, 8'hE5);
        load_pc(16'h1234);
        chk_regs("R10 regs before save");

        // R5/R6/R9: save with ignored writes and return during busy
        do_irq(1'b0, 1'b1);
        chk_regs("R6 R9 after save");
        chk("R6 I bit set", cc_out[3], 1);

        dec_wr(0, 8'h55); dec_wr(1, 8'h66); dec_wr(3, 8'h1F); load_pc(16'hBEEF);
        chk("R4 cc write 1F reads FF", cc_out, 8'hFF);

        // R7: restore
        do_rti;
        chk_regs("R7 after restore");
        chk("R7 saved I restored clear", cc_out[3], 0);

        // R3: stack pointer low byte and page wrap
        dec_wr(2, 8'h00);
        chk("R3 sp write keeps page", sp_out, 16'h0100);
        do_irq(1'b0, 1'b0);
        chk("R3 sp wrapped in page", sp_out, 16'h01FB);
        do_rti;
        chk_regs("R3 after wrap restore");

        // R11: simultaneous requests favour the save
        do_irq(1'b1, 1'b0);
        chk_regs("R11 save wins");
        do_rti;
        chk_regs("R11 cleanup restore");

        tick;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule